// File: doc/BRIEF.md
# Checksummed Command Responder on a Two-Wire Target Port

This block is a two-wire bus target (I2C electrical style, SMBus-like framing) that lets a system manager query and configure a module through short register-style commands. Every exchange is two transfers. First the manager writes a command byte, an optional data byte and a zero-sum checksum. Then it addresses the block for reading and clocks out a response. That response is the echoed command, a payload and a closing checksum that brings the byte sum to zero.

The block holds the bit-level target state machine. SCL and SDA are sampled through synchronisers, and SDA is driven only as an open-drain pull-down. The 7-bit address is formed from two active-low slot-position pins, which are debounced after reset and then frozen.

Three commands are recognised:
- an 8-bit status register, readable and writable;
- a query that returns the frozen address;
- a sensor readback that returns a parallel register input, split into bytes.

Status bit 7 is a guarded override. It can only be set by three identical status writes in a row.

Top module: `smb_cmd_responder`

## Requirements
- R1: The 7-bit address is binary 01000 followed by the inverted GA1 level and then the inverted GA0 level. With both pins high the address is 0x20, so the write byte is 0x40 and the read byte is 0x41. No address byte is acknowledged until the pins have held one value for DEBOUNCE_CYCLES clocks after reset.
- R2: Once latched, the address stays fixed until reset, whatever the pins do afterwards.
- R3: Each response ends with a checksum byte chosen so that the 8-bit sum of the echo, the payload and the checksum is 0. A request is accepted only if the 8-bit sum of all its bytes after the address byte is 0.
- R4: A response is the echoed command byte, then the payload, then the checksum. Multi-byte values are sent most significant byte first, and every byte is sent most significant bit first.
- R5: Command 0x55 with no data byte reads the status register. In the returned byte, bit 1 is the live INHIBIT* pin level and bit 0 is the live ENABLE* pin level. Bits 7 to 2 read 0 after reset.
- R6: Command 0x55 with one data byte writes status bits 6 to 2 from that byte. Bits 1 and 0 are not affected by a write.
- R7: Status bit 7 is set only when a write carries bit 7 set and is the third consecutive valid status write with an identical data byte. A valid status write with bit 7 clear clears it. Any other valid request breaks the run.
- R8: A request with a bad checksum or an illegal length is discarded and leaves the status register unchanged. The next read returns 0xFF for every byte.
- R9: A command byte other than 0x55, 0x45 or 0x90 is not acknowledged, and it clears any pending response. A following read returns 0xFF bytes.
- R10: Command 0x45 returns the latched 7-bit address as a byte with bit 7 clear.
- R11: Command 0x90 returns SENS_BYTES payload bytes taken from the sensor input, with the most significant byte of the input sent first.
- R12: The target only pulls SDA low or releases it. It releases SDA when idle and while it is receiving bits.
- R13: An address byte that does not match the latched address is not acknowledged, and the block stays off the bus until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_low_o | output | 1 | 1 pulls the data line low; 0 releases it |
| geo_addr_n_i | input | 2 | Slot position pins, active low: bit 1 is GA1, bit 0 is GA0 |
| inhibit_n_i | input | 1 | INHIBIT* pin level, reported in status bit 1 |
| enable_n_i | input | 1 | ENABLE* pin level, reported in status bit 0 |
| sensor_data_i | input | SENS_BYTES*8 | Parallel sensor value returned by command 0x90 |

## Verification
The embedded assertions watch several properties on every clock:
- the latched address never moves;
- the data line is released while idle or receiving;
- an address is only acknowledged once the address has latched;
- a rejected request never changes the status register;
- the override bit only rises at the end of a three-write run;
- an unknown command always empties the pending response.

The exact byte streams can only be shown by the bench's bus transactions: echo order, byte order, checksum values, 0xFF filler and the address value itself. The same goes for acknowledge timing on matching and non-matching addresses, and for how the override run is broken by intervening requests.

// File: rtl/smbr_pkg.sv
package smbr_pkg;

   localparam logic [7:0] CMD_STATUS = 8'h55;
   localparam logic [7:0] CMD_HWADDR = 8'h45;
   localparam logic [7:0] CMD_SENSOR = 8'h90;
   localparam logic [7:0] FILL_BYTE  = 8'hFF;
   localparam logic [4:0] ADDR_BASE  = 5'b01000;

   typedef enum logic [2:0] {
      TS_IDLE,
      TS_ADDR,
      TS_ADDR_ACK,
      TS_WDATA,
      TS_WACK,
      TS_RDATA,
      TS_RACK
   } tgt_state_t;

   typedef enum logic [1:0] {
      PEND_NONE,
      PEND_FILL,
      PEND_CMD
   } pend_kind_t;

   function automatic logic cmd_known(input logic [7:0] c);
      return (c == CMD_STATUS) || (c == CMD_HWADDR) || (c == CMD_SENSOR);
   endfunction

   function automatic logic [7:0] neg8(input logic [7:0] s);
      return 8'(~s + 8'd1);
   endfunction

endpackage

// File: rtl/smbr_sync.sv
module smbr_sync #(
   parameter int               STAGES    = 2,
   parameter int               WIDTH     = 1,
   parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("smbr_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("smbr_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RESET_VAL;
            else        stg[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RESET_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/smbr_addr_latch.sv
module smbr_addr_latch
   import smbr_pkg::*;
#(
   parameter int DEBOUNCE_CYCLES = 500_000,
   parameter int SYNC_STAGES     = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] geo_n_raw,
   output logic [6:0] addr7,
   output logic       addr_valid
);

   localparam int CW = $clog2(DEBOUNCE_CYCLES + 1);

   if (DEBOUNCE_CYCLES < 1) begin : g_bad_db
      $error("smbr_addr_latch: DEBOUNCE_CYCLES must be positive");
   end

   logic [1:0]    geo_s;
   logic [1:0]    geo_prev;
   logic [CW-1:0] stable_cnt;

   smbr_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RESET_VAL(2'b11)) u_geo_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (geo_n_raw),
      .q    (geo_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         geo_prev   <= 2'b11;
         stable_cnt <= '0;
         addr7      <= '0;
         addr_valid <= 1'b0;
      end else if (!addr_valid) begin
         if (geo_s != geo_prev) begin
            geo_prev   <= geo_s;
            stable_cnt <= '0;
         end else if (stable_cnt == CW'(DEBOUNCE_CYCLES - 1)) begin
            addr_valid <= 1'b1;
            addr7      <= {ADDR_BASE, ~geo_s[1], ~geo_s[0]};
         end else begin
            stable_cnt <= stable_cnt + 1'b1;
         end
      end
   end

   // R2: address frozen after latch
   a_r2_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |=> (addr_valid && $stable(addr7)));

endmodule

// File: rtl/smbr_i2c_target.sv
module smbr_i2c_target
   import smbr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_s,
   input  logic       sda_s,
   input  logic [6:0] addr7,
   input  logic       addr_valid,
   input  logic       eng_ack,
   input  logic [7:0] rd_byte,
   output logic       sda_low,
   output logic [7:0] wr_data,
   output logic       wr_begin,
   output logic       wr_stb,
   output logic       wr_end,
   output logic       rd_begin,
   output logic       rd_take
);

   tgt_state_t state;
   logic       scl_q, sda_q;
   logic [3:0] bit_cnt;
   logic [7:0] shreg;
   logic       rw;
   logic       in_write;
   logic       mst_ack;

   logic scl_rise, scl_fall, start_c, stop_c;
   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

   assign wr_data = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= TS_IDLE;
         bit_cnt  <= '0;
         shreg    <= '0;
         rw       <= 1'b0;
         in_write <= 1'b0;
         mst_ack  <= 1'b0;
         sda_low  <= 1'b0;
         wr_begin <= 1'b0;
         wr_stb   <= 1'b0;
         wr_end   <= 1'b0;
         rd_begin <= 1'b0;
         rd_take  <= 1'b0;
      end else begin
         wr_begin <= 1'b0;
         wr_stb   <= 1'b0;
         wr_end   <= 1'b0;
         rd_begin <= 1'b0;
         rd_take  <= 1'b0;
         if (stop_c) begin
            state    <= TS_IDLE;
            sda_low  <= 1'b0;
            wr_end   <= in_write;
            in_write <= 1'b0;
         end else if (start_c) begin
            state    <= TS_ADDR;
            bit_cnt  <= '0;
            sda_low  <= 1'b0;
            wr_end   <= in_write;
            in_write <= 1'b0;
         end else begin
            unique case (state)
               TS_IDLE: ;
               TS_ADDR, TS_WDATA: begin
                  if (scl_rise) begin
                     shreg   <= {shreg[6:0], sda_s};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall && bit_cnt == 4'd8) begin
                     if (state == TS_ADDR) begin
                        if (addr_valid && shreg[7:1] == addr7) begin
                           sda_low <= 1'b1;
                           rw      <= shreg[0];
                           state   <= TS_ADDR_ACK;
                           if (shreg[0]) rd_begin <= 1'b1;
                           else begin
                              wr_begin <= 1'b1;
                              in_write <= 1'b1;
                           end
                        end else begin
                           state <= TS_IDLE;
                        end
                     end else begin
                        wr_stb <= 1'b1;
                        if (eng_ack) begin
                           sda_low <= 1'b1;
                           state   <= TS_WACK;
                        end else begin
                           state    <= TS_IDLE;
                           in_write <= 1'b0;
                        end
                     end
                  end
               end
               TS_ADDR_ACK: begin
                  if (scl_fall) begin
                     if (rw) begin
                        shreg   <= rd_byte;
                        rd_take <= 1'b1;
                        sda_low <= ~rd_byte[7];
                        bit_cnt <= 4'd1;
                        state   <= TS_RDATA;
                     end else begin
                        sda_low <= 1'b0;
                        bit_cnt <= '0;
                        state   <= TS_WDATA;
                     end
                  end
               end
               TS_WACK: begin
                  if (scl_fall) begin
                     sda_low <= 1'b0;
                     bit_cnt <= '0;
                     state   <= TS_WDATA;
                  end
               end
               TS_RDATA: begin
                  if (scl_fall) begin
                     if (bit_cnt == 4'd8) begin
                        sda_low <= 1'b0;
                        state   <= TS_RACK;
                     end else begin
                        sda_low <= ~shreg[6];
                        shreg   <= {shreg[6:0], 1'b0};
                        bit_cnt <= bit_cnt + 1'b1;
                     end
                  end
               end
               TS_RACK: begin
                  if (scl_rise) begin
                     mst_ack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (mst_ack) begin
                        shreg   <= rd_byte;
                        rd_take <= 1'b1;
                        sda_low <= ~rd_byte[7];
                        bit_cnt <= 4'd1;
                        state   <= TS_RDATA;
                     end else begin
                        state <= TS_IDLE;
                     end
                  end
               end
               default: state <= TS_IDLE;
            endcase
         end
      end
   end

   // R12: line released while idle
   a_r12_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TS_IDLE) |-> !sda_low);
   // R12: line released while the manager sends bits
   a_r12_rx_released: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TS_ADDR || state == TS_WDATA) |-> !sda_low);
   // R1: no acknowledge before the address has latched
   a_r1_ack_needs_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TS_ADDR_ACK) |-> addr_valid);

endmodule

// File: rtl/smbr_cmd_engine.sv
module smbr_cmd_engine
   import smbr_pkg::*;
#(
   parameter int SENS_BYTES = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [7:0]              wr_data,
   input  logic                    wr_begin,
   input  logic                    wr_stb,
   input  logic                    wr_end,
   input  logic                    rd_begin,
   input  logic                    rd_take,
   input  logic [6:0]              addr7,
   input  logic                    inhibit_n_s,
   input  logic                    enable_n_s,
   input  logic [SENS_BYTES*8-1:0] sensor,
   output logic                    eng_ack,
   output logic [7:0]              rd_byte
);

   localparam int RSP_MAX = SENS_BYTES + 2;
   localparam int IDXW    = $clog2(RSP_MAX + 1) + 1;

   if (SENS_BYTES < 1 || SENS_BYTES > 16) begin : g_bad_sens
      $error("smbr_cmd_engine: SENS_BYTES must be 1..16");
   end

   // request capture
   logic [2:0] req_cnt;
   logic [7:0] req_cmd, req_data, req_sum;
   // pending response
   pend_kind_t pend_kind;
   logic [7:0] pend_cmd;
   // status register
   logic       ovr;
   logic [4:0] st_mid;
   logic [7:0] streak_byte;
   logic [1:0] streak_cnt;
   // response walk
   logic [IDXW-1:0] rsp_idx;
   logic [7:0]      rsp_sum;
   logic [1:0]      snap_pins;

   logic [7:0] sens_b [SENS_BYTES];
   for (genvar k = 0; k < SENS_BYTES; k++) begin : g_sens_split
      assign sens_b[k] = sensor[(SENS_BYTES-1-k)*8 +: 8];
   end

   assign eng_ack = (req_cnt == 3'd0) ? cmd_known(wr_data) : 1'b1;

   logic req_len_ok, req_ok;
   always_comb begin
      if (req_cmd == CMD_STATUS) req_len_ok = (req_cnt == 3'd2) || (req_cnt == 3'd3);
      else                       req_len_ok = (req_cnt == 3'd2);
      req_ok = req_len_ok && (req_sum == 8'd0) && cmd_known(req_cmd);
   end

   logic [1:0] streak_nxt;
   always_comb begin
      if (streak_cnt != 2'd0 && req_data == streak_byte)
         streak_nxt = (streak_cnt == 2'd3) ? 2'd3 : streak_cnt + 2'd1;
      else
         streak_nxt = 2'd1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_cnt     <= '0;
         req_cmd     <= '0;
         req_data    <= '0;
         req_sum     <= '0;
         pend_kind   <= PEND_NONE;
         pend_cmd    <= '0;
         ovr         <= 1'b0;
         st_mid      <= '0;
         streak_byte <= '0;
         streak_cnt  <= '0;
      end else begin
         if (wr_begin) begin
            req_cnt <= '0;
            req_sum <= '0;
         end else if (wr_stb) begin
            req_sum <= req_sum + wr_data;
            if (req_cnt != 3'd4) req_cnt <= req_cnt + 3'd1;
            if (req_cnt == 3'd0) begin
               req_cmd <= wr_data;
               if (!cmd_known(wr_data)) pend_kind <= PEND_NONE;
            end
            if (req_cnt == 3'd1) req_data <= wr_data;
         end else if (wr_end && req_cnt != 3'd0) begin
            if (req_ok) begin
               pend_kind <= PEND_CMD;
               pend_cmd  <= req_cmd;
               if (req_cmd == CMD_STATUS && req_cnt == 3'd3) begin
                  st_mid      <= req_data[6:2];
                  streak_byte <= req_data;
                  streak_cnt  <= streak_nxt;
                  if (!req_data[7])              ovr <= 1'b0;
                  else if (streak_nxt == 2'd3)   ovr <= 1'b1;
               end else begin
                  streak_cnt <= '0;
               end
            end else begin
               pend_kind <= PEND_FILL;
            end
         end
      end
   end

   logic [IDXW-1:0] rsp_len;
   logic [IDXW-1:0] pidx;
   logic [7:0]      payload;
   always_comb begin
      unique case (pend_cmd)
         CMD_SENSOR: rsp_len = IDXW'(RSP_MAX);
         default:    rsp_len = IDXW'(3);
      endcase
      pidx    = rsp_idx - 1'b1;
      payload = FILL_BYTE;
      if (pend_cmd == CMD_STATUS)      payload = {ovr, st_mid, snap_pins};
      else if (pend_cmd == CMD_HWADDR) payload = {1'b0, addr7};
      else begin
         for (int k = 0; k < SENS_BYTES; k++)
            if (pidx == IDXW'(k)) payload = sens_b[k];
      end
      if (pend_kind != PEND_CMD || rsp_idx >= rsp_len) rd_byte = FILL_BYTE;
      else if (rsp_idx == '0)                          rd_byte = pend_cmd;
      else if (rsp_idx == rsp_len - 1'b1)              rd_byte = neg8(rsp_sum);
      else                                             rd_byte = payload;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_idx   <= '0;
         rsp_sum   <= '0;
         snap_pins <= 2'b11;
      end else if (rd_begin) begin
         rsp_idx   <= '0;
         rsp_sum   <= '0;
         snap_pins <= {inhibit_n_s, enable_n_s};
      end else if (rd_take) begin
         rsp_sum <= rsp_sum + rd_byte;
         if (rsp_idx < rsp_len) rsp_idx <= rsp_idx + 1'b1;
      end
   end

   // R8: rejected request leaves status untouched
   a_r8_reject_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_end && req_cnt != 3'd0 && !req_ok) |=> $stable({ovr, st_mid}));
   // R7: override rises only at the end of a three-write run
   a_r7_override_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> (streak_cnt == 2'd3 && streak_byte[7]));
   // R9: unknown command empties the pending response
   a_r9_unknown_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && req_cnt == 3'd0 && !eng_ack) |=> (pend_kind == PEND_NONE));
   // R6: status bits only move on a completed request
   a_r6_status_on_end: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_end) |-> $stable(st_mid));

endmodule

// File: rtl/smb_cmd_responder.sv
module smb_cmd_responder
   import smbr_pkg::*;
#(
   parameter int SYNC_STAGES     = 2,
   parameter int DEBOUNCE_CYCLES = 500_000,
   parameter int SENS_BYTES      = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    scl_i,
   input  logic                    sda_i,
   output logic                    sda_pull_low_o,
   input  logic [1:0]              geo_addr_n_i,
   input  logic                    inhibit_n_i,
   input  logic                    enable_n_i,
   input  logic [SENS_BYTES*8-1:0] sensor_data_i
);

   logic [3:0] lines_s;
   logic [6:0] addr7;
   logic       addr_valid;
   logic       eng_ack;
   logic [7:0] rd_byte, wr_data;
   logic       wr_begin, wr_stb, wr_end, rd_begin, rd_take;

   smbr_sync #(.STAGES(SYNC_STAGES), .WIDTH(4), .RESET_VAL(4'hF)) u_line_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({scl_i, sda_i, inhibit_n_i, enable_n_i}),
      .q    (lines_s)
   );

   smbr_addr_latch #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .geo_n_raw (geo_addr_n_i),
      .addr7     (addr7),
      .addr_valid(addr_valid)
   );

   smbr_i2c_target u_tgt (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (lines_s[3]),
      .sda_s     (lines_s[2]),
      .addr7     (addr7),
      .addr_valid(addr_valid),
      .eng_ack   (eng_ack),
      .rd_byte   (rd_byte),
      .sda_low   (sda_pull_low_o),
      .wr_data   (wr_data),
      .wr_begin  (wr_begin),
      .wr_stb    (wr_stb),
      .wr_end    (wr_end),
      .rd_begin  (rd_begin),
      .rd_take   (rd_take)
   );

   smbr_cmd_engine #(.SENS_BYTES(SENS_BYTES)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_data    (wr_data),
      .wr_begin   (wr_begin),
      .wr_stb     (wr_stb),
      .wr_end     (wr_end),
      .rd_begin   (rd_begin),
      .rd_take    (rd_take),
      .addr7      (addr7),
      .inhibit_n_s(lines_s[1]),
      .enable_n_s (lines_s[0]),
      .sensor     (sensor_data_i),
      .eng_ack    (eng_ack),
      .rd_byte    (rd_byte)
   );

endmodule

// File: tb/smb_cmd_responder_bench.sv
module smb_cmd_responder_bench;

   localparam int DEB = 1500;
   localparam int SB  = 4;
   localparam int Q   = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic sda_low;
   logic sda_bus;
   logic [1:0] ga_n = 2'b10;
   logic inh_n = 1'b1, en_n = 1'b0;
   logic [SB*8-1:0] sensor_v = 32'hA1B2_C3D4;

   assign sda_bus = sda_m & ~sda_low;

   always #5 clk = ~clk;

   smb_cmd_responder #(.DEBOUNCE_CYCLES(DEB), .SENS_BYTES(SB)) u_smb_cmd_responder (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_pull_low_o(sda_low), .geo_addr_n_i(ga_n),
      .inhibit_n_i(inh_n), .enable_n_i(en_n), .sensor_data_i(sensor_v)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // bus primitives
   task automatic bw(input int n); repeat (n) @(negedge clk); endtask

   task automatic i2c_start;
      sda_m = 1'b1; bw(Q); scl_m = 1'b1; bw(Q); sda_m = 1'b0; bw(Q); scl_m = 1'b0; bw(Q);
   endtask

   task automatic i2c_stop;
      sda_m = 1'b0; bw(Q); scl_m = 1'b1; bw(Q); sda_m = 1'b1; bw(2*Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; bw(Q); scl_m = 1'b1; bw(2*Q); scl_m = 1'b0; bw(Q);
      end
      sda_m = 1'b1; bw(Q); scl_m = 1'b1; bw(Q); ack = ~sda_bus; bw(Q); scl_m = 1'b0; bw(Q);
   endtask

   task automatic recv_byte(input bit ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         bw(Q); scl_m = 1'b1; bw(Q); b[i] = sda_bus; bw(Q); scl_m = 1'b0;
      end
      bw(Q); sda_m = ~ack; bw(Q); scl_m = 1'b1; bw(2*Q); scl_m = 1'b0; bw(Q); sda_m = 1'b1;
   endtask

   // write request: n bytes from pk (MSB first); returns index of first NACK or -1
   task automatic wr_req(input logic [7:0] ab, input logic [23:0] pk, input int n, output int nack_at);
      bit a;
      nack_at = -1;
      i2c_start;
      send_byte(ab, a);
      if (!a) nack_at = 0;
      for (int i = 0; i < n && nack_at < 0; i++) begin
         send_byte(pk[23-8*i -: 8], a);
         if (!a) nack_at = i + 1;
      end
      i2c_stop;
   endtask

   task automatic rd_rsp(input logic [7:0] ab, input int n, output logic [7:0] b [8], output bit aok);
      for (int i = 0; i < 8; i++) b[i] = 8'h00;
      i2c_start;
      send_byte(ab, aok);
      if (aok)
         for (int i = 0; i < n; i++) recv_byte(i != n-1, b[i]);
      i2c_stop;
   endtask

   // reference model
   logic [7:0] m_st = 8'h00;
   logic [7:0] m_run_b = 8'h00;
   int         m_run = 0;
   int         m_kind = 0;     // 0 none, 1 filler, 2 response
   logic [7:0] m_cmd = 8'h00;
   logic [6:0] m_addr = 7'h21;
   logic [7:0] WA, RA;

   function automatic logic [7:0] ck(input logic [7:0] a, input logic [7:0] b);
      return 8'(~(a + b) + 8'd1);
   endfunction

   task automatic status_write(input logic [7:0] d, input bit good);
      int na;
      wr_req(WA, {8'h55, d, good ? ck(8'h55, d) : ck(8'h55, d) ^ 8'h01}, 3, na);
      chk(na == -1, "R6 write acked", 32'(na), 32'hFFFFFFFF);
      if (good) begin
         m_run = (m_run != 0 && d == m_run_b) ? ((m_run == 3) ? 3 : m_run + 1) : 1;
         m_run_b = d;
         m_st[6:2] = d[6:2];
         if (!d[7]) m_st[7] = 1'b0;
         else if (m_run == 3) m_st[7] = 1'b1;
         m_kind = 2; m_cmd = 8'h55;
      end else m_kind = 1;
   endtask

   task automatic simple_req(input logic [7:0] c);
      int na;
      wr_req(WA, {c, ck(c, 8'h00), 8'h00}, 2, na);
      chk(na == -1, "R4 request acked", 32'(na), 32'hFFFFFFFF);
      m_run = 0; m_kind = 2; m_cmd = c;
   endtask

   task automatic expect_rsp(input string req);
      logic [7:0] exp [8];
      logic [7:0] got [8];
      bit aok;
      int n;
      logic [7:0] s;
      for (int i = 0; i < 8; i++) exp[i] = 8'hFF;
      n = 3;
      if (m_kind == 2) begin
         exp[0] = m_cmd;
         if (m_cmd == 8'h55)      exp[1] = {m_st[7:2], inh_n, en_n};
         else if (m_cmd == 8'h45) exp[1] = {1'b0, m_addr};
         else begin
            n = SB + 2;
            for (int k = 0; k < SB; k++) exp[1+k] = sensor_v[(SB-1-k)*8 +: 8];
         end
         s = 8'h00;
         for (int k = 0; k < n-1; k++) s = s + exp[k];
         exp[n-1] = 8'(~s + 8'd1);
      end
      rd_rsp(RA, n, got, aok);
      chk(aok, {req, " read addr ack"}, 32'(aok), 32'd1);
      s = 8'h00;
      for (int i = 0; i < n; i++) begin
         chk(got[i] == exp[i], $sformatf("%s byte %0d", req, i), 32'(got[i]), 32'(exp[i]));
         s = s + got[i];
      end
      if (m_kind == 2) chk(s == 8'h00, "R3 zero sum", 32'(s), 32'h0);
   endtask

   initial begin
      int na;
      bit a;
      logic [7:0] d;
      void'($urandom(32'd20250611));
      WA = 8'h42; RA = 8'h43;
      bw(4);
      chk(sda_low == 1'b0, "R12 released in reset", 32'(sda_low), 32'h0);
      rst_n = 1'b1;
      bw(2);
      chk(sda_low == 1'b0, "R12 released after reset", 32'(sda_low), 32'h0);
      // R1: address not acknowledged during debounce
      i2c_start; send_byte(8'h42, a); i2c_stop;
      chk(!a, "R1 no ack before latch", 32'(a), 32'h0);
      bw(DEB + 200);
      // R1 address 0x21 with GA1 high, GA0 low; R2 freeze
      ga_n = 2'b01;
      bw(50);
      i2c_start; send_byte(8'h44, a); i2c_stop;
      chk(!a, "R2 new pin value ignored", 32'(a), 32'h0);
      i2c_start; send_byte(8'h40, a); i2c_stop;
      chk(!a, "R13 foreign address nacked", 32'(a), 32'h0);
      chk(sda_low == 1'b0, "R13 bus released", 32'(sda_low), 32'h0);
      // R5 reset status read
      simple_req(8'h55);
      expect_rsp("R5 status after reset");
      // R10 address query
      simple_req(8'h45);
      expect_rsp("R10 address query");
      // R11 sensor readback
      simple_req(8'h90);
      expect_rsp("R11 sensor readback");
      // R6 write 0x18 -> 0x1A
      status_write(8'h18, 1'b1);
      simple_req(8'h55);
      expect_rsp("R6 status write");
      // R7 override run
      status_write(8'h84, 1'b1); status_write(8'h84, 1'b1);
      simple_req(8'h55); expect_rsp("R7 two writes no override");
      status_write(8'h84, 1'b1); status_write(8'h84, 1'b1); status_write(8'h84, 1'b1);
      chk(m_st[7] == 1'b1, "R7 model set", 32'(m_st[7]), 32'h1);
      simple_req(8'h55); expect_rsp("R7 override set");
      status_write(8'h00, 1'b1);
      status_write(8'h8C, 1'b1); status_write(8'h8C, 1'b1); status_write(8'h88, 1'b1); status_write(8'h8C, 1'b1);
      simple_req(8'h55); expect_rsp("R7 broken run");
      // R8 bad checksum
      status_write(8'h7C, 1'b0);
      expect_rsp("R8 filler after bad checksum");
      simple_req(8'h55); expect_rsp("R8 status unchanged");
      // R9 unknown command
      wr_req(WA, {8'h33, ck(8'h33, 8'h00), 8'h00}, 2, na);
      chk(na == 1, "R9 unknown nacked", 32'(na), 32'd1);
      m_kind = 0;
      expect_rsp("R9 filler after unknown");
      // random mix
      for (int it = 0; it < 16; it++) begin
         int op;
         op = $urandom_range(0, 4);
         inh_n = 1'($urandom_range(0, 1));
         en_n  = 1'($urandom_range(0, 1));
         bw(10);
         case (op)
            0: begin
               d = ($urandom_range(0, 1) == 1) ? m_run_b : 8'($urandom);
               status_write(d, 1'b1);
               expect_rsp("R7 random status write");
            end
            1: begin simple_req(8'h55); expect_rsp("R5 random status read"); end
            2: begin simple_req(8'h45); expect_rsp("R10 random address query"); end
            3: begin
               sensor_v = $urandom;
               simple_req(8'h90); expect_rsp("R11 random sensor");
            end
            default: begin
               status_write(8'($urandom), 1'b0);
               expect_rsp("R8 random bad checksum");
            end
         endcase
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (190000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule